// File: doc/BRIEF.md
# Standby Clock Gate Controller

This block decides when a processor core's pipeline clock runs. A one-cycle wait pulse from the pipeline freezes the core: the pipeline clock enable drops and the standby flag rises, so the pipeline keeps its state until it is released. The controller itself never stops. Its interval timer keeps counting, and the interrupt, reset and external request pins are still sampled through synchronizer flops while the pipeline is frozen.

Any pending wake source restores the clock enable on the edge after it is seen. The wake sources are an unmasked interrupt line, the non-maskable interrupt, an external request or the timer's own compare interrupt. When the pipeline resumes, it continues from where it stopped. A warm or cold reset also ends standby, and in that case a one-cycle `wake_reset` pulse tells the core to run its reset sequence and not to resume. A wait pulse that arrives while a wake source is already present is ignored.

Top module: `standby_ctrl`

## Requirements
- R1: When the controller is running, a `wait_pulse` high at a clock edge with no wake source present sets `standby` to 1 and `pipe_clk_en` to 0 from that edge.
- R2: `pipe_clk_en` always equals the inverse of `standby`, and it stays 0 on every edge while standby continues without a wake source.
- R3: The interval timer adds one on every edge, in standby as well as in run, and wraps at 2^TMR_W. `tmr_irq` goes to 1 on the edge after the count equals the compare value. The compare value is loaded from `cmp_value` on an edge where `cmp_load` is 1.
- R4: `tmr_ack` high at an edge clears `tmr_irq`, unless a compare match occurs at that same edge, in which case `tmr_irq` stays 1.
- R5: The pins `irq_n`, `nmi_n`, `ext_req_n`, `sys_reset_n` and `cold_reset_n` are active-low and pass through SYNC_STAGES (default 2) flops. A low level on `irq_n[i]` is a wake source only when `irq_en[i]` is 1. `nmi_n`, `ext_req_n` and a set `tmr_irq` are always wake sources. A pin driven low before edge k clears `standby` at edge k+2.
- R6: An interrupt line whose `irq_en` bit is 0 never ends standby.
- R7: A low `sys_reset_n` or `cold_reset_n` ends standby, and `wake_reset` is 1 for exactly the one cycle after that exit. `wake_reset` is 0 after every other kind of exit and at all other times.
- R8: A `wait_pulse` at an edge where any wake source, reset included, is present leaves `standby` at 0.
- R9: While `rst_n` is low, `standby` is 0, `pipe_clk_en` is 1, `tmr_irq` is 0 and `wake_reset` is 0. The timer count resets to 0 and the compare value resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| wait_pulse | input | 1 | One-cycle request from the pipeline to enter standby |
| irq_n | input | 6 | Active-low maskable interrupt lines |
| irq_en | input | 6 | Per-line wake enable for `irq_n` |
| nmi_n | input | 1 | Active-low non-maskable interrupt |
| ext_req_n | input | 1 | Active-low external request |
| sys_reset_n | input | 1 | Active-low warm reset pin |
| cold_reset_n | input | 1 | Active-low cold reset pin |
| cmp_load | input | 1 | Loads `cmp_value` into the timer compare register |
| cmp_value | input | TMR_W | New compare value |
| tmr_ack | input | 1 | Clears the timer interrupt |
| pipe_clk_en | output | 1 | Pipeline clock enable |
| standby | output | 1 | Pipeline frozen flag |
| tmr_irq | output | 1 | Timer compare interrupt pending |
| wake_reset | output | 1 | One-cycle pulse after a reset-caused exit from standby |

## Verification
Directed sequences cover each way in and out of standby on its own. A masked line against an unmasked line shows that the enable mask works. NMI held during a wait pulse shows that a pending wake blocks entry. A compare value programmed while the pipeline is frozen shows that the timer really keeps running. A warm reset against an interrupt wake tells the reset exit apart from a resume. After these, long runs of seeded random pin activity, wait pulses, compare loads and acknowledges are compared cycle by cycle with a bench model. These runs find errors in the synchronizer latency and in the priority between timer set and clear that the sparse directed cases can miss.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int unsigned N_IRQ = 6;
    // irq lines, nmi, ext request, warm reset, cold reset
    localparam int unsigned N_PINS = N_IRQ + 4;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STBY = 1'b1
    } stby_state_e;

    typedef struct packed {
        stby_state_e st;
        logic        clk_en;
        logic        wake_rst;
    } fsm_reg_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned WIDTH   = 10,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pins_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pins_out = chain_q[STAGES-1];

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> chain_q[0] == $past(pins_in)) else $error("sync stage"); // R5

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer #(
    parameter int unsigned TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_load,
    input  logic [TMR_W-1:0] cmp_value,
    input  logic             tmr_ack,
    output logic             tmr_irq
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic [TMR_W-1:0] cmp;
        logic             pend;
    } tmr_reg_t;

    tmr_reg_t t_d, t_q;
    logic     match;

    always_comb begin
        t_d     = t_q;
        match   = (t_q.cnt == t_q.cmp);
        t_d.cnt = t_q.cnt + 1'b1;
        if (cmp_load) begin
            t_d.cmp = cmp_value;
        end
        t_d.pend = match | (t_q.pend & ~tmr_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt  <= '0;
            t_q.cmp  <= '1;
            t_q.pend <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tmr_irq = t_q.pend;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> t_q.cnt == $past(t_q.cnt) + 1'b1) else $error("count step"); // R3
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> tmr_irq) else $error("match lost"); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ack && !match) |=> !tmr_irq) else $error("ack ignored"); // R4

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_pulse,
    input  logic pend_wake,
    input  logic rst_wake,
    output logic standby,
    output logic clk_en,
    output logic wake_rst
);

    fsm_reg_t f_d, f_q;
    logic     any_wake;

    always_comb begin
        any_wake   = pend_wake | rst_wake;
        f_d        = f_q;
        f_d.wake_rst = 1'b0;
        unique case (f_q.st)
            ST_RUN: begin
                if (wait_pulse && !any_wake) begin
                    f_d.st = ST_STBY;
                end
            end
            ST_STBY: begin
                if (any_wake) begin
                    f_d.st       = ST_RUN;
                    f_d.wake_rst = rst_wake;
                end
            end
            default: f_d.st = ST_RUN;
        endcase
        f_d.clk_en = (f_d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st       <= ST_RUN;
            f_q.clk_en   <= 1'b1;
            f_q.wake_rst <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign standby  = (f_q.st == ST_STBY);
    assign clk_en   = f_q.clk_en;
    assign wake_rst = f_q.wake_rst;

    AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && wait_pulse && !any_wake) |=> (standby && !clk_en)) else $error("no entry"); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !any_wake) |=> (standby && !clk_en)) else $error("early exit"); // R2
    AST_EN_INV: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en != standby) else $error("enable mismatch"); // R2
    AST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && any_wake) |=> (!standby && clk_en)) else $error("no exit"); // R5
    AST_NO_ENTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && any_wake) |=> !standby) else $error("entered with wake"); // R8
    AST_WAKE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |-> ($past(standby) && !standby)) else $error("stray reset pulse"); // R7

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned TMR_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_pulse,
    input  logic [5:0]       irq_n,
    input  logic [5:0]       irq_en,
    input  logic             nmi_n,
    input  logic             ext_req_n,
    input  logic             sys_reset_n,
    input  logic             cold_reset_n,
    input  logic             cmp_load,
    input  logic [TMR_W-1:0] cmp_value,
    input  logic             tmr_ack,
    output logic             pipe_clk_en,
    output logic             standby,
    output logic             tmr_irq,
    output logic             wake_reset
);

    localparam int unsigned NMI_BIT  = N_IRQ;
    localparam int unsigned EXT_BIT  = N_IRQ + 1;
    localparam int unsigned WRST_BIT = N_IRQ + 2;
    localparam int unsigned CRST_BIT = N_IRQ + 3;

    logic [N_PINS-1:0] raw_pins, sync_pins_n, sync_act;
    logic              pend_wake, rst_wake;

    assign raw_pins = {cold_reset_n, sys_reset_n, ext_req_n, nmi_n, irq_n};

    pin_sync #(
        .WIDTH   (N_PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({N_PINS{1'b1}})
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (raw_pins),
        .pins_out (sync_pins_n)
    );

    ivl_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_load  (cmp_load),
        .cmp_value (cmp_value),
        .tmr_ack   (tmr_ack),
        .tmr_irq   (tmr_irq)
    );

    always_comb begin
        sync_act  = ~sync_pins_n;
        pend_wake = (|(sync_act[N_IRQ-1:0] & irq_en)) | sync_act[NMI_BIT]
                  | sync_act[EXT_BIT] | tmr_irq;
        rst_wake  = sync_act[WRST_BIT] | sync_act[CRST_BIT];
    end

    stby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_pulse (wait_pulse),
        .pend_wake  (pend_wake),
        .rst_wake   (rst_wake),
        .standby    (standby),
        .clk_en     (pipe_clk_en),
        .wake_rst   (wake_reset)
    );

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !rst_wake && !tmr_irq && sync_act[NMI_BIT] == 1'b0
         && sync_act[EXT_BIT] == 1'b0 && (sync_act[N_IRQ-1:0] & irq_en) == '0)
        |=> standby) else $error("masked wake"); // R6

endmodule

// File: tb/standby_ctrl_tb.sv
`timescale 1ns/1ps
module standby_ctrl_tb;

    localparam int TMR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wait_pulse = 1'b0;
    logic [5:0]       irq_n = '1;
    logic [5:0]       irq_en = '0;
    logic             nmi_n = 1'b1;
    logic             ext_req_n = 1'b1;
    logic             sys_reset_n = 1'b1;
    logic             cold_reset_n = 1'b1;
    logic             cmp_load = 1'b0;
    logic [TMR_W-1:0] cmp_value = '0;
    logic             tmr_ack = 1'b0;
    logic             pipe_clk_en, standby, tmr_irq, wake_reset;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [9:0]       m_s1, m_s2;
    logic [TMR_W-1:0] m_cnt, m_cmp;
    logic             m_pend, m_stby, m_wrst;

    always #5 clk = ~clk;

    standby_ctrl #(.TMR_W(TMR_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wait_pulse(wait_pulse), .irq_n(irq_n),
        .irq_en(irq_en), .nmi_n(nmi_n), .ext_req_n(ext_req_n),
        .sys_reset_n(sys_reset_n), .cold_reset_n(cold_reset_n),
        .cmp_load(cmp_load), .cmp_value(cmp_value), .tmr_ack(tmr_ack),
        .pipe_clk_en(pipe_clk_en), .standby(standby), .tmr_irq(tmr_irq),
        .wake_reset(wake_reset)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = '1; m_s2 = '1; m_cnt = '0; m_cmp = '1;
        m_pend = 1'b0; m_stby = 1'b0; m_wrst = 1'b0;
    endtask

    function automatic logic [1:0] wakes(input logic [9:0] s2n, input logic [5:0] en, input logic pend);
        logic [9:0] a;
        a = ~s2n;
        wakes[0] = (|(a[5:0] & en)) | a[6] | a[7] | pend;
        wakes[1] = a[8] | a[9];
    endfunction

    task automatic model_step();
        logic [1:0] w;
        logic       any, match;
        w     = wakes(m_s2, irq_en, m_pend);
        any   = |w;
        match = (m_cnt == m_cmp);
        m_wrst = m_stby & w[1];
        if (m_stby) m_stby = !any;
        else        m_stby = wait_pulse && !any;
        m_pend = match | (m_pend & ~tmr_ack);
        m_cnt  = m_cnt + 1'b1;
        if (cmp_load) m_cmp = cmp_value;
        m_s2 = m_s1;
        m_s1 = {cold_reset_n, sys_reset_n, ext_req_n, nmi_n, irq_n};
    endtask

    task automatic compare();
        chk(standby == m_stby, "R1 standby", 32'(standby), 32'(m_stby));
        chk(pipe_clk_en == !m_stby, "R2 pipe_clk_en", 32'(pipe_clk_en), 32'(!m_stby));
        chk(tmr_irq == m_pend, "R3 tmr_irq", 32'(tmr_irq), 32'(m_pend));
        chk(wake_reset == m_wrst, "R7 wake_reset", 32'(wake_reset), 32'(m_wrst));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle_pins();
        wait_pulse = 0; irq_n = '1; nmi_n = 1; ext_req_n = 1;
        sys_reset_n = 1; cold_reset_n = 1; cmp_load = 0; tmr_ack = 0;
    endtask

    task automatic enter_standby();
        wait_pulse = 1; cyc(); wait_pulse = 0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(standby == 0, "R9 standby", 32'(standby), 0);
        chk(pipe_clk_en == 1, "R9 pipe_clk_en", 32'(pipe_clk_en), 1);
        chk(tmr_irq == 0, "R9 tmr_irq", 32'(tmr_irq), 0);
        chk(wake_reset == 0, "R9 wake_reset", 32'(wake_reset), 0);
        rst_n = 1;
        repeat (3) cyc();

        // R1 entry, R2 held low
        enter_standby();
        chk(standby == 1, "R1 entry", 32'(standby), 1);
        repeat (5) cyc();
        chk(pipe_clk_en == 0, "R2 still frozen", 32'(pipe_clk_en), 0);

        // R6 masked line
        irq_en = 6'b000000; irq_n[2] = 0;
        repeat (6) cyc();
        chk(standby == 1, "R6 masked irq ignored", 32'(standby), 1);
        irq_n = '1; repeat (3) cyc();

        // R5 unmasked line, exact latency
        irq_en = 6'b001000; irq_n[3] = 0;
        cyc();
        chk(standby == 1, "R5 latency edge1", 32'(standby), 1);
        cyc();
        chk(standby == 1, "R5 latency edge2", 32'(standby), 1);
        cyc();
        chk(standby == 0, "R5 wake edge3", 32'(standby), 0);
        irq_n = '1; irq_en = '0; repeat (3) cyc();

        // R8 wait with pending NMI
        nmi_n = 0; repeat (3) cyc();
        wait_pulse = 1; cyc(); wait_pulse = 0;
        chk(standby == 0, "R8 wait ignored", 32'(standby), 0);
        nmi_n = 1; repeat (3) cyc();

        // R3 timer runs in standby and wakes
        enter_standby();
        cmp_load = 1; cmp_value = m_cnt + 16'd20; cyc(); cmp_load = 0;
        for (int i = 0; i < 40 && !tmr_irq; i++) cyc();
        chk(tmr_irq == 1, "R3 timer match", 32'(tmr_irq), 1);
        cyc();
        chk(standby == 0, "R3 timer wake", 32'(standby), 0);
        // R4 ack
        tmr_ack = 1; cyc(); tmr_ack = 0;
        chk(tmr_irq == 0, "R4 ack clears", 32'(tmr_irq), 0);
        // R4 set wins over ack
        cmp_load = 1; cmp_value = m_cnt + 16'd1; cyc(); cmp_load = 0;
        tmr_ack = 1; cyc(); tmr_ack = 0;
        chk(tmr_irq == 1, "R4 match beats ack", 32'(tmr_irq), 1);
        tmr_ack = 1; cyc(); tmr_ack = 0; cyc();

        // R7 reset exit
        enter_standby();
        chk(standby == 1, "R7 pre standby", 32'(standby), 1);
        sys_reset_n = 0; repeat (3) cyc();
        chk(standby == 0, "R7 reset exit", 32'(standby), 0);
        chk(wake_reset == 1, "R7 pulse", 32'(wake_reset), 1);
        sys_reset_n = 1; cyc();
        chk(wake_reset == 0, "R7 pulse one cycle", 32'(wake_reset), 0);
        repeat (3) cyc();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            wait_pulse   = ($urandom % 5) == 0;
            for (int b = 0; b < 6; b++) irq_n[b] = ($urandom % 40) != 0;
            nmi_n        = ($urandom % 80) != 0;
            ext_req_n    = ($urandom % 80) != 0;
            sys_reset_n  = ($urandom % 200) != 0;
            cold_reset_n = ($urandom % 200) != 0;
            if (($urandom % 50) == 0) irq_en = 6'($urandom);
            tmr_ack      = ($urandom % 4) == 0;
            cmp_load     = ($urandom % 40) == 0;
            cmp_value    = m_cnt + 16'($urandom % 64);
            cyc();
        end
        idle_pins();
        repeat (4) cyc();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule